// File: doc/BRIEF.md
# Auto-Acking Prioritized Interrupt Controller

This block gathers a parameterized set of level-sensitive hardware interrupt lines and hands them out to several processors. Every source has a software-trigger bit that is ORed with its line, a mask bit, and a routing register that names the processors allowed to take it. Mask and software bits are changed through paired set and clear windows, so one write can change any group of bits in a word without a read-modify-write.

Each processor has a level IRQ output. Its handler reads the event register, which reports the lowest-numbered pending, unmasked source routed to that processor. The same read acknowledges that source by setting its mask bit. The handler must clear the mask bit again when it finishes the interrupt. The register bus carries the index of the requesting processor with every access. Read data is registered and appears in the cycle after the request.

Top module: `aicx_top`

## Requirements
- R1: After reset every source is masked, every software bit is clear, and every routing register holds 1 (processor 0 only).
- R2: A source is pending when its hardware line is high or its software bit is set. The software bits are set at offset 0x100 + 4*w and cleared at 0x140 + 4*w. Either window reads back word w.
- R3: Mask bits are set at 0x180 + 4*w and cleared at 0x1C0 + 4*w, where w = n>>5 and the bit is n mod 32. Written ones act and written zeros leave their bit unchanged. Either window reads back the current word.
- R4: The event register at 0x008 returns the type in bits 31:16, with 1 meaning a hardware source, and the source number in bits 15:0. The read data is valid in the cycle after the request.
- R5: A read of the event register that reports a source sets the mask bit of that source in the same step.
- R6: When several eligible sources are pending, the lowest-numbered one is reported.
- R7: The routing register of source n sits at 0x400 + 4*n and holds a one-hot processor mask, with bit c meaning processor c. A source reaches only the processors whose bit is set.
- R8: An event read by a processor with nothing eligible returns zero and changes no mask bit.
- R9: irq_o[c] is high exactly while some unmasked, pending source is routed to processor c. It follows the hardware line level.
- R10: The info register at 0x000 returns the number of sources in bits 15:0. The identity register at 0x004 returns the index of the requesting processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_i | input | NUM_SRC | Level interrupt lines |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the requesting processor |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_CPU | Per-processor interrupt request |

## Verification
The bench builds the block with 64 sources and two processors. With 64 sources the mask and software bits span two words, so the word-select arithmetic is exercised across a word boundary and a lower-numbered source in the upper word can be set against a higher one. With two processors, the tests can route a source away from processor 0. They then check that processor 0 reads an empty event while processor 1 receives that source.

// File: rtl/aicx_pkg.sv
// Package: register offsets and event encoding shared by the controller.
// Assumes a 12-bit byte address space, word-aligned accesses.
package aicx_pkg;
    localparam logic [11:0] OFF_INFO   = 12'h000;
    localparam logic [11:0] OFF_WHOAMI = 12'h004;
    localparam logic [11:0] OFF_EVENT  = 12'h008;
    // Window selectors: bus_addr[11:6]
    localparam logic [5:0]  WIN_SW_SET   = 6'h04;
    localparam logic [5:0]  WIN_SW_CLR   = 6'h05;
    localparam logic [5:0]  WIN_MSK_SET  = 6'h06;
    localparam logic [5:0]  WIN_MSK_CLR  = 6'h07;
    // Routing area selector: bus_addr[11:10]
    localparam logic [1:0]  WIN_ROUTE    = 2'b01;
    localparam logic [15:0] EV_TYPE_HW   = 16'd1;

    typedef struct packed {
        logic [15:0] kind;
        logic [15:0] num;
    } aicx_event_t;
endpackage

// File: rtl/aicx_bitvec.sv
// Module: one bit per source, changed through set and clear word writes plus
// a single-bit acknowledge set. Assumes at most one of set/clr per cycle.
module aicx_bitvec #(
    parameter int NUM_SRC    = 64,
    parameter bit RESET_ONES = 1'b0,
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [3:0]         word_sel,
    input  logic [31:0]        wdata,
    input  logic               ack_en,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] bits_o
);
    logic [NUM_SRC-1:0] bits_q;
    logic [NUM_SRC-1:0] wmask_vec;

    // Expand the written word into a per-source strobe vector.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_strobe
        assign wmask_vec[n] = (word_sel == 4'(n / 32)) && wdata[n % 32];
    end

    // Apply set, clear and acknowledge to the stored bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= RESET_ONES ? '1 : '0;
        end else begin
            if (set_en) bits_q <= bits_q | wmask_vec;
            else if (clr_en) bits_q <= bits_q & ~wmask_vec;
            else if (ack_en) bits_q[ack_idx] <= 1'b1;
        end
    end

    assign bits_o = bits_q;

    // R5
    ack_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |=> bits_q[$past(ack_idx)]);

    // R3
    set_only_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((bits_q & ~$past(bits_q) & ~$past(wmask_vec)) == '0));

    // R3
    clr_only_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((~bits_q & $past(bits_q) & ~$past(wmask_vec)) == '0));
endmodule

// File: rtl/aicx_route.sv
// Module: per-source routing registers holding a one-hot processor mask.
// Assumes software writes a one-hot value; any value is stored as written.
module aicx_route #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [NUM_CPU-1:0]              wdata,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0] route_o
);
    logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;

    // Hold the routing masks; reset points every source at processor 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_SRC; n++) route_q[n] <= NUM_CPU'(1);
        end else if (wr_en) begin
            route_q[wr_idx] <= wdata;
        end
    end

    assign route_o = route_q;

    // R7
    route_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> route_q[$past(wr_idx)] == $past(wdata));
endmodule

// File: rtl/aicx_pick.sv
// Module: lowest-index selector over the eligible sources of one processor.
// Assumes cand is already masked and routed; output is combinational.
module aicx_pick #(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_SRC-1:0] grant;

    // Isolate the lowest set bit.
    assign grant = cand & (~cand + NUM_SRC'(1));
    assign valid = |cand;

    // Encode the one-hot grant into a source number.
    always_comb begin
        idx = '0;
        for (int n = 0; n < NUM_SRC; n++)
            if (grant[n]) idx = idx | IDX_W'(n);
    end

    // R6
    always_comb begin
        lowest_wins_chk: assert (!valid || (cand[idx] &&
            ((cand & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0)));
        one_grant_chk: assert ($onehot0(grant));
    end
endmodule

// File: rtl/aicx_top.sv
// Module: interrupt controller top. Decodes the register bus, combines
// lines with software bits, masks and routes them, and reports events.
// Assumes one bus access per cycle and word-aligned addresses.
module aicx_top #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int NWORDS = (NUM_SRC + 31) / 32,
    localparam int PADW   = NWORDS * 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_irq_i,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] irq_o
);
    import aicx_pkg::*;

    logic [NUM_SRC-1:0]              mask_bits, sw_bits, eff_pend;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] route;
    logic [NUM_CPU-1:0]              pick_v;
    logic [IDX_W-1:0]                pick_idx [NUM_CPU];
    logic                            acc, sel_v, ev_rd;
    logic [IDX_W-1:0]                sel_idx;
    logic [5:0]                      win;
    logic [3:0]                      word_sel;
    logic [7:0]                      route_sel;
    logic                            route_hit;
    logic [PADW-1:0]                 mask_pad, sw_pad;
    logic [31:0]                     rd_next;
    aicx_event_t                     ev;

    assign acc       = bus_req && (bus_addr[1:0] == 2'b00);
    assign win       = bus_addr[11:6];
    assign word_sel  = bus_addr[5:2];
    assign route_sel = bus_addr[9:2];
    assign route_hit = (bus_addr[11:10] == WIN_ROUTE) && (32'(route_sel) < NUM_SRC);
    assign ev_rd     = acc && !bus_we && (bus_addr == OFF_EVENT);

    aicx_bitvec #(.NUM_SRC(NUM_SRC), .RESET_ONES(1'b1)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .set_en(acc && bus_we && win == WIN_MSK_SET),
        .clr_en(acc && bus_we && win == WIN_MSK_CLR),
        .word_sel(word_sel), .wdata(bus_wdata),
        .ack_en(ev_rd && sel_v), .ack_idx(sel_idx),
        .bits_o(mask_bits)
    );

    aicx_bitvec #(.NUM_SRC(NUM_SRC), .RESET_ONES(1'b0)) u_soft (
        .clk(clk), .rst_n(rst_n),
        .set_en(acc && bus_we && win == WIN_SW_SET),
        .clr_en(acc && bus_we && win == WIN_SW_CLR),
        .word_sel(word_sel), .wdata(bus_wdata),
        .ack_en(1'b0), .ack_idx('0),
        .bits_o(sw_bits)
    );

    aicx_route #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_route (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc && bus_we && route_hit),
        .wr_idx(IDX_W'(route_sel)),
        .wdata(bus_wdata[NUM_CPU-1:0]),
        .route_o(route)
    );

    assign eff_pend = hw_irq_i | sw_bits;

    // One selector per processor over its masked, routed sources.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SRC-1:0] cand;
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign cand[n] = eff_pend[n] && !mask_bits[n] && route[n][c];
        end
        aicx_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .cand(cand), .valid(pick_v[c]), .idx(pick_idx[c])
        );
        assign irq_o[c] = pick_v[c];
    end

    // Choose the selector result of the requesting processor.
    always_comb begin
        sel_v   = 1'b0;
        sel_idx = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (32'(bus_cpu) == c) begin
                sel_v   = pick_v[c];
                sel_idx = pick_idx[c];
            end
        end
    end

    assign mask_pad = PADW'(mask_bits);
    assign sw_pad   = PADW'(sw_bits);
    assign ev.kind  = sel_v ? EV_TYPE_HW : 16'd0;
    assign ev.num   = sel_v ? 16'(sel_idx) : 16'd0;

    // Build the read data for the addressed register.
    always_comb begin
        rd_next = '0;
        if (bus_addr == OFF_INFO)        rd_next = 32'(NUM_SRC) & 32'h0000_FFFF;
        else if (bus_addr == OFF_WHOAMI) rd_next = 32'(bus_cpu);
        else if (bus_addr == OFF_EVENT)  rd_next = ev;
        else if (win == WIN_SW_SET || win == WIN_SW_CLR) begin
            if (32'(word_sel) < NWORDS) rd_next = sw_pad[32*word_sel +: 32];
        end else if (win == WIN_MSK_SET || win == WIN_MSK_CLR) begin
            if (32'(word_sel) < NWORDS) rd_next = mask_pad[32*word_sel +: 32];
        end else if (route_hit) rd_next = 32'(route[route_sel[IDX_W-1:0]]);
    end

    // Register the read data for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (acc && !bus_we)    bus_rdata <= rd_next;
    end

    // R8
    empty_event_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd && !sel_v) |=> ($stable(mask_bits) && bus_rdata == 32'd0));

    // R4
    event_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd |=> (bus_rdata[31:16] == 16'd0 || bus_rdata[31:16] == EV_TYPE_HW));

    // R9
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> ((eff_pend & ~mask_bits) != '0));
endmodule

// File: tb/aicx_top_bench.sv
module aicx_top_bench;
    localparam int NSRC = 64;
    localparam int NCPU = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] hw = '0;
    logic            bus_req = 1'b0, bus_we = 1'b0;
    logic [0:0]      bus_cpu = '0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCPU-1:0] irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    aicx_top #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) u_aicx_top (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw),
        .bus_req(bus_req), .bus_we(bus_we), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq)
    );

    // Vector: {hw lines, mask-clear pattern, expected processor-0 event}
    localparam logic [159:0] VEC [6] = '{
        {64'h0,                 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0000},
        {64'h0000_0000_0000_0220, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0001_0005},
        {64'h0000_0000_0000_0220, 64'h0000_0000_0000_0200, 32'h0001_0009},
        {64'h0000_0100_0000_0000, 64'h0000_0100_0000_0000, 32'h0001_0028},
        {64'h8000_0002_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0001_0021},
        {64'h0000_0000_0000_0001, 64'h0,                 32'h0000_0000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_cpu = 1'(cpu); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_cpu = 1'(cpu); bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        hw = '1;
        #1 check(irq == 2'b00, "R1 irq masked", 32'(irq), 32'h0);
        rd(0, 12'h180, d); check(d == 32'hFFFF_FFFF, "R1 mask word0", d, 32'hFFFF_FFFF);
        rd(0, 12'h184, d); check(d == 32'hFFFF_FFFF, "R1 mask word1", d, 32'hFFFF_FFFF);
        rd(0, 12'h100, d); check(d == 32'h0, "R1 soft word0", d, 32'h0);
        rd(0, 12'h47C, d); check(d == 32'h1, "R1 route 31", d, 32'h1);
        hw = '0;

        // R4 R6 vector table
        for (int i = 0; i < 6; i++) begin
            wr(0, 12'h180, '1); wr(0, 12'h184, '1);
            wr(0, 12'h140, '1); wr(0, 12'h144, '1);
            hw = VEC[i][159:96];
            wr(0, 12'h1C0, VEC[i][63:32]);
            wr(0, 12'h1C4, VEC[i][95:64]);
            rd(0, 12'h008, d);
            check(d == VEC[i][31:0], "R6 R4 event vector", d, VEC[i][31:0]);
        end

        // R5 acknowledge masks the source
        hw = 64'h8;
        wr(0, 12'h1C0, 32'h8);
        #1 check(irq[0] == 1'b1, "R9 irq raised", 32'(irq), 32'h1);
        rd(0, 12'h008, d); check(d == 32'h0001_0003, "R5 event", d, 32'h0001_0003);
        rd(0, 12'h180, d); check(d == 32'hFFFF_FFFF, "R5 mask set by ack", d, 32'hFFFF_FFFF);
        check(irq[0] == 1'b0, "R5 irq drops", 32'(irq), 32'h0);
        // R8 empty read
        rd(0, 12'h008, d); check(d == 32'h0, "R8 empty event", d, 32'h0);
        rd(0, 12'h1C0, d); check(d == 32'hFFFF_FFFF, "R8 mask unchanged", d, 32'hFFFF_FFFF);

        // R3 zero bits and window readback
        wr(0, 12'h1C0, 32'h0);
        rd(0, 12'h1C0, d); check(d == 32'hFFFF_FFFF, "R3 zero clear", d, 32'hFFFF_FFFF);
        wr(0, 12'h180, 32'h0);
        rd(0, 12'h184, d); check(d == 32'hFFFF_FFFF, "R3 zero set", d, 32'hFFFF_FFFF);
        wr(0, 12'h1C0, 32'h8);
        rd(0, 12'h180, d); check(d == 32'hFFFF_FFF7, "R3 clear one bit", d, 32'hFFFF_FFF7);
        #1 check(irq[0] == 1'b1, "R9 irq unmasked", 32'(irq), 32'h1);
        hw = '0;
        #1 check(irq[0] == 1'b0, "R9 level follows line", 32'(irq), 32'h0);
        wr(0, 12'h180, 32'h8);

        // R2 software trigger on source 50
        wr(0, 12'h104, 32'h0004_0000);
        wr(0, 12'h1C4, 32'h0004_0000);
        #1 check(irq[0] == 1'b1, "R2 soft raises irq", 32'(irq), 32'h1);
        rd(0, 12'h144, d); check(d == 32'h0004_0000, "R2 soft readback", d, 32'h0004_0000);
        rd(0, 12'h008, d); check(d == 32'h0001_0032, "R2 soft event", d, 32'h0001_0032);
        wr(0, 12'h144, 32'h0004_0000);
        wr(0, 12'h1C4, 32'h0004_0000);
        #1 check(irq[0] == 1'b0, "R2 soft cleared", 32'(irq), 32'h0);

        // R7 routing source 12 to processor 1
        wr(0, 12'h430, 32'h2);
        rd(0, 12'h430, d); check(d == 32'h2, "R7 route readback", d, 32'h2);
        hw = 64'h1000;
        wr(0, 12'h1C0, 32'h1000);
        #1 check(irq == 2'b10, "R7 irq on cpu1 only", 32'(irq), 32'h2);
        rd(0, 12'h008, d); check(d == 32'h0, "R7 cpu0 sees nothing", d, 32'h0);
        rd(1, 12'h008, d); check(d == 32'h0001_000C, "R7 cpu1 event", d, 32'h0001_000C);

        // R10 info and identity
        rd(0, 12'h000, d); check(d == 32'd64, "R10 info", d, 32'd64);
        rd(1, 12'h004, d); check(d == 32'd1, "R10 whoami", d, 32'd1);

        finish_run();
    end
endmodule